// File: doc/BRIEF.md
# Five-Stage Pipeline Staging Registers

This block contains the four inter-stage registers of a five-stage 32-bit integer pipeline: fetch to decode, decode to execute, execute to memory, and memory to writeback. On each clock it captures the values that the current stage produced and passes them to the next stage. Any value that only travels along the chain is taken from the previous register inside the block, so it does not need its own input. Examples are the incremented PC, the store data, the destination register number, and the control groups.

Decode produces three control groups: execute, memory and writeback. All three enter the decode/execute register. The execute group is dropped after that register, and the memory group is dropped after the execute/memory register. Only the writeback group reaches the last register. The fetch/decode register has a stall input that holds its contents. The fetch/decode and decode/execute registers each have a flush input that turns their slot into a bubble. The stage logic (ALU, memories, register file, decoder) lies outside the block.

Top module: `pipe_stage_chain`

## Requirements
- R1: While rst_ni is low, every output is zero, so the pipeline starts filled with no-ops.
- R2: When neither stall nor flush is active, the fetch/decode register loads if_instr_i and if_pc_inc_i on each rising clock edge.
- R3: When ifid_stall_i is high and ifid_flush_i is low, the fetch/decode register keeps its instruction and PC+4 unchanged for that cycle.
- R4: When ifid_flush_i is high, the fetch/decode instruction becomes 32'h0 (the no-op encoding) and PC+4 is still loaded. Flush takes priority over stall.
- R5: The decode/execute register loads both operand values, the immediate, the destination number and the three control groups from its inputs. It takes its PC+4 from the fetch/decode output.
- R6: When idex_flush_i is high, the execute control field (alu_op[3:2], alu_src[1], reg_dst[0]), the memory field (branch[2], mem_read[1], mem_write[0]) and the writeback field (reg_write[1], mem_to_reg[0]) of decode/execute all become zero. Its data fields still load.
- R7: The execute/memory register loads the branch target, ALU result and zero flag from its inputs. It takes store data from the decode/execute second operand, and its destination number, memory field and writeback field from decode/execute.
- R8: The memory/writeback register loads the memory read data from its input. It takes its ALU result, destination number and writeback field from execute/memory.
- R9: A writeback control group accepted by decode/execute appears unchanged at the memory/writeback output two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| if_instr_i | input | 32 | Fetched instruction |
| if_pc_inc_i | input | 32 | Fetch PC+4 |
| ifid_stall_i | input | 1 | Hold the fetch/decode register |
| ifid_flush_i | input | 1 | Bubble the fetch/decode register |
| id_rs_val_i | input | 32 | First register read value |
| id_rt_val_i | input | 32 | Second register read value |
| id_imm_i | input | 32 | Sign-extended immediate |
| id_dst_i | input | 5 | Destination register number |
| id_ex_ctrl_i | input | 4 | Execute control group |
| id_mem_ctrl_i | input | 3 | Memory control group |
| id_wb_ctrl_i | input | 2 | Writeback control group |
| idex_flush_i | input | 1 | Bubble the decode/execute register |
| ex_br_target_i | input | 32 | Computed branch target |
| ex_alu_i | input | 32 | ALU result |
| ex_zero_i | input | 1 | ALU zero flag |
| mem_rdata_i | input | 32 | Data memory read value |
| ifid_instr_o | output | 32 | Fetch/decode instruction |
| ifid_pc_inc_o | output | 32 | Fetch/decode PC+4 |
| idex_rs_val_o | output | 32 | Decode/execute first operand |
| idex_rt_val_o | output | 32 | Decode/execute second operand |
| idex_imm_o | output | 32 | Decode/execute immediate |
| idex_pc_inc_o | output | 32 | Decode/execute PC+4 |
| idex_dst_o | output | 5 | Decode/execute destination |
| idex_ex_o | output | 4 | Decode/execute execute group |
| idex_mem_o | output | 3 | Decode/execute memory group |
| idex_wb_o | output | 2 | Decode/execute writeback group |
| exmem_br_target_o | output | 32 | Execute/memory branch target |
| exmem_alu_o | output | 32 | Execute/memory ALU result |
| exmem_zero_o | output | 1 | Execute/memory zero flag |
| exmem_st_data_o | output | 32 | Execute/memory store data |
| exmem_dst_o | output | 5 | Execute/memory destination |
| exmem_mem_o | output | 3 | Execute/memory memory group |
| exmem_wb_o | output | 2 | Execute/memory writeback group |
| memwb_alu_o | output | 32 | Memory/writeback ALU result |
| memwb_rdata_o | output | 32 | Memory/writeback read data |
| memwb_dst_o | output | 5 | Memory/writeback destination |
| memwb_wb_o | output | 2 | Memory/writeback writeback group |

## Verification
The bench targets the following corner cases:

- **Stall and flush on the same edge.** A design with the wrong priority would keep a stale instruction that should have become a no-op.
- **Long stall runs.** A hold that leaks would advance the instruction or its PC+4.
- **Decode/execute flush with all control bits set.** A partial clear would leave a store or register write alive in the bubble.
- **Chained fields.** PC+4, store data, destination and writeback bits are each traced across several registers. A register that took the wrong source, or that skipped or duplicated a stage, would deliver the value one cycle early, one cycle late, or from the wrong operand.

// File: rtl/pipe_stage_pkg.sv
package pipe_stage_pkg;
  localparam int unsigned EX_CTRL_W  = 4;  // alu_op[3:2], alu_src[1], reg_dst[0]
  localparam int unsigned MEM_CTRL_W = 3;  // branch[2], mem_read[1], mem_write[0]
  localparam int unsigned WB_CTRL_W  = 2;  // reg_write[1], mem_to_reg[0]
  localparam int unsigned IDEX_CTRL_W  = EX_CTRL_W + MEM_CTRL_W + WB_CTRL_W;
  localparam int unsigned EXMEM_CTRL_W = MEM_CTRL_W + WB_CTRL_W;
endpackage

// File: rtl/stage_reg.sv
// One staging register: ctrl part cleared on clr_i, data part always loads unless held.
module stage_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] d_data_i,
  input  logic [CTRL_W-1:0] d_ctrl_i,
  output logic [DATA_W-1:0] q_data_o,
  output logic [CTRL_W-1:0] q_ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_data_o <= '0;
      q_ctrl_o <= '0;
    end else if (clr_i) begin
      q_data_o <= d_data_i;
      q_ctrl_o <= '0;
    end else if (!hold_i) begin
      q_data_o <= d_data_i;
      q_ctrl_o <= d_ctrl_i;
    end
  end

  assert_clear_ctrl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_ctrl_o == '0));
  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i) |=> ($stable(q_ctrl_o) && $stable(q_data_o)));
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !clr_i) |=> (q_ctrl_o == $past(d_ctrl_i) && q_data_o == $past(d_data_i)));
endmodule

// File: rtl/pipe_stage_chain.sv
module pipe_stage_chain
  import pipe_stage_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [XLEN-1:0]       if_instr_i,
  input  logic [XLEN-1:0]       if_pc_inc_i,
  input  logic                  ifid_stall_i,
  input  logic                  ifid_flush_i,
  input  logic [XLEN-1:0]       id_rs_val_i,
  input  logic [XLEN-1:0]       id_rt_val_i,
  input  logic [XLEN-1:0]       id_imm_i,
  input  logic [RA_W-1:0]       id_dst_i,
  input  logic [EX_CTRL_W-1:0]  id_ex_ctrl_i,
  input  logic [MEM_CTRL_W-1:0] id_mem_ctrl_i,
  input  logic [WB_CTRL_W-1:0]  id_wb_ctrl_i,
  input  logic                  idex_flush_i,
  input  logic [XLEN-1:0]       ex_br_target_i,
  input  logic [XLEN-1:0]       ex_alu_i,
  input  logic                  ex_zero_i,
  input  logic [XLEN-1:0]       mem_rdata_i,
  output logic [XLEN-1:0]       ifid_instr_o,
  output logic [XLEN-1:0]       ifid_pc_inc_o,
  output logic [XLEN-1:0]       idex_rs_val_o,
  output logic [XLEN-1:0]       idex_rt_val_o,
  output logic [XLEN-1:0]       idex_imm_o,
  output logic [XLEN-1:0]       idex_pc_inc_o,
  output logic [RA_W-1:0]       idex_dst_o,
  output logic [EX_CTRL_W-1:0]  idex_ex_o,
  output logic [MEM_CTRL_W-1:0] idex_mem_o,
  output logic [WB_CTRL_W-1:0]  idex_wb_o,
  output logic [XLEN-1:0]       exmem_br_target_o,
  output logic [XLEN-1:0]       exmem_alu_o,
  output logic                  exmem_zero_o,
  output logic [XLEN-1:0]       exmem_st_data_o,
  output logic [RA_W-1:0]       exmem_dst_o,
  output logic [MEM_CTRL_W-1:0] exmem_mem_o,
  output logic [WB_CTRL_W-1:0]  exmem_wb_o,
  output logic [XLEN-1:0]       memwb_alu_o,
  output logic [XLEN-1:0]       memwb_rdata_o,
  output logic [RA_W-1:0]       memwb_dst_o,
  output logic [WB_CTRL_W-1:0]  memwb_wb_o
);
  localparam int unsigned IDEX_DATA_W  = 4*XLEN + RA_W;
  localparam int unsigned EXMEM_DATA_W = 3*XLEN + 1 + RA_W;
  localparam int unsigned MEMWB_DATA_W = 2*XLEN + RA_W;

  // IF/ID: the instruction sits in the clearable part so a flush yields an all-zero no-op
  stage_reg #(.DATA_W(XLEN), .CTRL_W(XLEN)) u_ifid (
    .clk_i, .rst_ni,
    .hold_i  (ifid_stall_i),
    .clr_i   (ifid_flush_i),
    .d_data_i(if_pc_inc_i),
    .d_ctrl_i(if_instr_i),
    .q_data_o(ifid_pc_inc_o),
    .q_ctrl_o(ifid_instr_o)
  );

  stage_reg #(.DATA_W(IDEX_DATA_W), .CTRL_W(IDEX_CTRL_W)) u_idex (
    .clk_i, .rst_ni,
    .hold_i  (1'b0),
    .clr_i   (idex_flush_i),
    .d_data_i({id_rs_val_i, id_rt_val_i, id_imm_i, ifid_pc_inc_o, id_dst_i}),
    .d_ctrl_i({id_ex_ctrl_i, id_mem_ctrl_i, id_wb_ctrl_i}),
    .q_data_o({idex_rs_val_o, idex_rt_val_o, idex_imm_o, idex_pc_inc_o, idex_dst_o}),
    .q_ctrl_o({idex_ex_o, idex_mem_o, idex_wb_o})
  );

  // EX group is consumed here and not carried on
  stage_reg #(.DATA_W(EXMEM_DATA_W), .CTRL_W(EXMEM_CTRL_W)) u_exmem (
    .clk_i, .rst_ni,
    .hold_i  (1'b0),
    .clr_i   (1'b0),
    .d_data_i({ex_br_target_i, ex_alu_i, ex_zero_i, idex_rt_val_o, idex_dst_o}),
    .d_ctrl_i({idex_mem_o, idex_wb_o}),
    .q_data_o({exmem_br_target_o, exmem_alu_o, exmem_zero_o, exmem_st_data_o, exmem_dst_o}),
    .q_ctrl_o({exmem_mem_o, exmem_wb_o})
  );

  // MEM group is consumed here; only WB goes on
  stage_reg #(.DATA_W(MEMWB_DATA_W), .CTRL_W(WB_CTRL_W)) u_memwb (
    .clk_i, .rst_ni,
    .hold_i  (1'b0),
    .clr_i   (1'b0),
    .d_data_i({exmem_alu_o, mem_rdata_i, exmem_dst_o}),
    .d_ctrl_i(exmem_wb_o),
    .q_data_o({memwb_alu_o, memwb_rdata_o, memwb_dst_o}),
    .q_ctrl_o(memwb_wb_o)
  );

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (idex_wb_o == '0 && exmem_mem_o == '0 && memwb_wb_o == '0 && ifid_instr_o == '0));
  assert_pc_chain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (idex_pc_inc_o == $past(ifid_pc_inc_o)));
  assert_mem_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (exmem_mem_o == $past(idex_mem_o) && exmem_st_data_o == $past(idex_rt_val_o)
              && exmem_dst_o == $past(idex_dst_o)));
  assert_wb_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (memwb_wb_o == $past(exmem_wb_o) && memwb_alu_o == $past(exmem_alu_o)));
  assert_wb_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |=> (memwb_wb_o == $past(idex_wb_o, 2)));
endmodule

// File: tb/pipe_stage_chain_test.sv
`timescale 1ns/1ps
module pipe_stage_chain_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] if_instr, if_pc_inc, id_rs, id_rt, id_imm, ex_tgt, ex_alu, mem_rd;
  logic [4:0]  id_dst;
  logic [3:0]  id_ex;
  logic [2:0]  id_mem;
  logic [1:0]  id_wb;
  logic        stall, fl_ifid, fl_idex, ex_zero;

  logic [31:0] ifid_instr, ifid_pc, idex_rs, idex_rt, idex_imm, idex_pc;
  logic [4:0]  idex_dst, exmem_dst, memwb_dst;
  logic [3:0]  idex_ex;
  logic [2:0]  idex_mem, exmem_mem;
  logic [1:0]  idex_wb, exmem_wb, memwb_wb;
  logic [31:0] exmem_tgt, exmem_alu, exmem_st, memwb_alu, memwb_rd;
  logic        exmem_zero;

  pipe_stage_chain uut (
    .clk_i(clk), .rst_ni(rst_n),
    .if_instr_i(if_instr), .if_pc_inc_i(if_pc_inc), .ifid_stall_i(stall), .ifid_flush_i(fl_ifid),
    .id_rs_val_i(id_rs), .id_rt_val_i(id_rt), .id_imm_i(id_imm), .id_dst_i(id_dst),
    .id_ex_ctrl_i(id_ex), .id_mem_ctrl_i(id_mem), .id_wb_ctrl_i(id_wb), .idex_flush_i(fl_idex),
    .ex_br_target_i(ex_tgt), .ex_alu_i(ex_alu), .ex_zero_i(ex_zero), .mem_rdata_i(mem_rd),
    .ifid_instr_o(ifid_instr), .ifid_pc_inc_o(ifid_pc),
    .idex_rs_val_o(idex_rs), .idex_rt_val_o(idex_rt), .idex_imm_o(idex_imm), .idex_pc_inc_o(idex_pc),
    .idex_dst_o(idex_dst), .idex_ex_o(idex_ex), .idex_mem_o(idex_mem), .idex_wb_o(idex_wb),
    .exmem_br_target_o(exmem_tgt), .exmem_alu_o(exmem_alu), .exmem_zero_o(exmem_zero),
    .exmem_st_data_o(exmem_st), .exmem_dst_o(exmem_dst), .exmem_mem_o(exmem_mem), .exmem_wb_o(exmem_wb),
    .memwb_alu_o(memwb_alu), .memwb_rdata_o(memwb_rd), .memwb_dst_o(memwb_dst), .memwb_wb_o(memwb_wb)
  );

  int n_chk = 0, n_bad = 0;

  // bench model of every output
  logic [31:0] e_ifid_instr, e_ifid_pc, e_idex_rs, e_idex_rt, e_idex_imm, e_idex_pc;
  logic [4:0]  e_idex_dst, e_exmem_dst, e_memwb_dst;
  logic [3:0]  e_idex_ex;
  logic [2:0]  e_idex_mem, e_exmem_mem;
  logic [1:0]  e_idex_wb, e_exmem_wb, e_memwb_wb, wb_hist1, wb_hist2;
  logic [31:0] e_exmem_tgt, e_exmem_alu, e_exmem_st, e_memwb_alu, e_memwb_rd;
  logic        e_exmem_zero;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_ifid_instr(input logic [31:0] cur, input logic [31:0] in,
                                                  input logic st, input logic fl);
    if (fl) return 32'h0;
    if (st) return cur;
    return in;
  endfunction

  task automatic model_clear();
    {e_ifid_instr, e_ifid_pc, e_idex_rs, e_idex_rt, e_idex_imm, e_idex_pc} = '0;
    {e_idex_dst, e_exmem_dst, e_memwb_dst, e_idex_ex, e_idex_mem, e_exmem_mem} = '0;
    {e_idex_wb, e_exmem_wb, e_memwb_wb, wb_hist1, wb_hist2} = '0;
    {e_exmem_tgt, e_exmem_alu, e_exmem_st, e_memwb_alu, e_memwb_rd, e_exmem_zero} = '0;
  endtask

  task automatic compare(input logic was_flush_ifid, input logic was_stall, input logic was_flush_idex);
    string ir;
    ir = was_flush_ifid ? "R4" : (was_stall ? "R3" : "R2");
    chk(ir, "ifid_instr", ifid_instr, e_ifid_instr);
    chk(ir, "ifid_pc", ifid_pc, e_ifid_pc);
    chk("R5", "idex_rs", idex_rs, e_idex_rs);
    chk("R5", "idex_rt", idex_rt, e_idex_rt);
    chk("R5", "idex_imm", idex_imm, e_idex_imm);
    chk("R5", "idex_pc", idex_pc, e_idex_pc);
    chk("R5", "idex_dst", {27'b0, idex_dst}, {27'b0, e_idex_dst});
    chk(was_flush_idex ? "R6" : "R5", "idex_ctrl", {23'b0, idex_ex, idex_mem, idex_wb},
        {23'b0, e_idex_ex, e_idex_mem, e_idex_wb});
    chk("R7", "exmem_tgt", exmem_tgt, e_exmem_tgt);
    chk("R7", "exmem_alu", exmem_alu, e_exmem_alu);
    chk("R7", "exmem_zero", {31'b0, exmem_zero}, {31'b0, e_exmem_zero});
    chk("R7", "exmem_st", exmem_st, e_exmem_st);
    chk("R7", "exmem_dst_ctrl", {22'b0, exmem_dst, exmem_mem, exmem_wb},
        {22'b0, e_exmem_dst, e_exmem_mem, e_exmem_wb});
    chk("R8", "memwb_alu", memwb_alu, e_memwb_alu);
    chk("R8", "memwb_rd", memwb_rd, e_memwb_rd);
    chk("R8", "memwb_dst", {27'b0, memwb_dst}, {27'b0, e_memwb_dst});
    chk("R9", "memwb_wb", {30'b0, memwb_wb}, {30'b0, wb_hist2});
  endtask

  // inputs already driven; advance model in reverse stage order, clock, then compare
  task automatic step();
    logic s, fi, fe;
    s = stall; fi = fl_ifid; fe = fl_idex;
    wb_hist2 = wb_hist1;
    wb_hist1 = e_idex_wb;
    e_memwb_alu = e_exmem_alu; e_memwb_rd = mem_rd; e_memwb_dst = e_exmem_dst; e_memwb_wb = e_exmem_wb;
    e_exmem_tgt = ex_tgt; e_exmem_alu = ex_alu; e_exmem_zero = ex_zero; e_exmem_st = e_idex_rt;
    e_exmem_dst = e_idex_dst; e_exmem_mem = e_idex_mem; e_exmem_wb = e_idex_wb;
    e_idex_rs = id_rs; e_idex_rt = id_rt; e_idex_imm = id_imm; e_idex_pc = e_ifid_pc; e_idex_dst = id_dst;
    if (fe) begin e_idex_ex = '0; e_idex_mem = '0; e_idex_wb = '0; end
    else begin e_idex_ex = id_ex; e_idex_mem = id_mem; e_idex_wb = id_wb; end
    e_ifid_instr = next_ifid_instr(e_ifid_instr, if_instr, s, fi);
    if (fi || !s) e_ifid_pc = if_pc_inc;
    @(posedge clk); #1;
    compare(fi, s, fe);
  endtask

  task automatic rand_inputs();
    if_instr = $urandom; if_pc_inc = $urandom; id_rs = $urandom; id_rt = $urandom;
    id_imm = $urandom; id_dst = 5'($urandom); id_ex = 4'($urandom); id_mem = 3'($urandom);
    id_wb = 2'($urandom); ex_tgt = $urandom; ex_alu = $urandom; ex_zero = 1'($urandom);
    mem_rd = $urandom;
    stall = ($urandom % 4) == 0; fl_ifid = ($urandom % 6) == 0; fl_idex = ($urandom % 6) == 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rand_inputs();
    id_wb = 2'b11; id_mem = 3'b111;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset holds everything at zero despite active inputs
    chk("R1", "memwb_wb", {30'b0, memwb_wb}, 32'h0);
    chk("R1", "idex_ctrl", {23'b0, idex_ex, idex_mem, idex_wb}, 32'h0);
    chk("R1", "ifid_instr", ifid_instr, 32'h0);
    chk("R1", "exmem_alu", exmem_alu, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // first edge after reset already loads; resync model to one known step
    model_clear();
    rand_inputs(); stall = 0; fl_ifid = 0; fl_idex = 0;
    e_ifid_instr = ifid_instr; e_ifid_pc = ifid_pc;
    e_idex_rs = idex_rs; e_idex_rt = idex_rt; e_idex_imm = idex_imm; e_idex_pc = idex_pc;
    e_idex_dst = idex_dst; e_idex_ex = idex_ex; e_idex_mem = idex_mem; e_idex_wb = idex_wb;
    e_exmem_tgt = exmem_tgt; e_exmem_alu = exmem_alu; e_exmem_zero = exmem_zero; e_exmem_st = exmem_st;
    e_exmem_dst = exmem_dst; e_exmem_mem = exmem_mem; e_exmem_wb = exmem_wb;
    e_memwb_alu = memwb_alu; e_memwb_rd = memwb_rd; e_memwb_dst = memwb_dst; e_memwb_wb = memwb_wb;
    wb_hist1 = exmem_wb; wb_hist2 = memwb_wb;
    repeat (4) step();

    // R3: long stall holds instruction and PC+4
    for (int i = 0; i < 5; i++) begin rand_inputs(); stall = 1; fl_ifid = 0; fl_idex = 0; step(); end
    // R4: stall and flush together, flush wins
    rand_inputs(); stall = 1; fl_ifid = 1; fl_idex = 0; step();
    chk("R4", "flushed_instr_nop", ifid_instr, 32'h0);
    // R6: flush decode/execute with all control bits set
    rand_inputs(); id_ex = 4'hF; id_mem = 3'h7; id_wb = 2'h3; stall = 0; fl_ifid = 0; fl_idex = 1; step();
    chk("R6", "idex_bubble", {23'b0, idex_ex, idex_mem, idex_wb}, 32'h0);
    // R9: full-ones writeback group, then let it travel
    rand_inputs(); id_wb = 2'h3; stall = 0; fl_ifid = 0; fl_idex = 0; step();
    rand_inputs(); id_wb = 2'h0; stall = 0; fl_ifid = 0; fl_idex = 0; step();
    rand_inputs(); id_wb = 2'h0; stall = 0; fl_ifid = 0; fl_idex = 0; step();
    chk("R9", "wb_arrives", {30'b0, memwb_wb}, 32'h3);

    for (int i = 0; i < 400; i++) begin rand_inputs(); step(); end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule